// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Thresholds and Rewind

A single-clock first-in first-out buffer for 9-bit words. Its depth is a power of two and is set by a parameter. Writes and reads are each gated by an active-low enable. Four active-low status outputs report the fill level: empty, full, almost empty and almost full. The almost-empty and almost-full thresholds are held in a pair of 9-bit offset fields. While the load control is low, both fields can be written through the data input and read back through the data output.

A rewind strobe moves the read side back to the first word written since reset. The words already delivered can then be read a second time. This only works while fewer words than the depth have been written since reset. An output-enable control gates the data output. It is modelled as a mask and a qualifying bit, not as a tristate driver. The output register keeps the last word that was validly read, and attempted reads on an empty buffer leave it unchanged.

Top module: `pflag_fifo`

## Requirements
- R1: While rst_n is low: empty_n is 0, full_n is 1, aempty_n is 0, afull_n is 1, and the data output register is 0. Both offsets are 7 after reset.
- R2: A clock edge with wr_n low, ld_n high and full_n high stores din. Reads with rd_n low, ld_n high and empty_n high return the stored words in the order they were written, one per edge, on dout.
- R3: A write attempted while full_n is low stores nothing, and full_n stays low.
- R4: A read attempted while empty_n is low leaves dout at the last word validly read, and empty_n stays low.
- R5: A read and a write on the same edge leave the word count unchanged.
- R6: aempty_n is low exactly when the count is at or below the almost-empty offset. With the default offset of 7, it goes high at 8 words.
- R7: afull_n is low exactly when the count is at or above the depth minus the almost-full offset. With depth 32 and the default offset, it goes low at 25 words.
- R8: While ld_n is low, write-enabled edges load din into the offset fields, the almost-empty field first and then the almost-full field. Nothing enters the buffer. The flags use the new offsets from the next edge on.
- R9: While ld_n is low, read-enabled edges put the almost-empty field and then the almost-full field on dout. Buffer contents are left unchanged.
- R10: When retx is high on an edge, the next read returns the first word written since reset. The count becomes the number of words written since reset. Reads and writes on that same edge are ignored.
- R11: With oe_n high, dout is 0 and dout_oe is 0. With oe_n low, dout shows the output register and dout_oe is 1.
- R12: full_n is low exactly when the buffer holds depth words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write enable |
| din | input | 9 | Write data or offset load value |
| rd_n | input | 1 | Active-low read enable |
| ld_n | input | 1 | Low selects the offset fields for loads and read-back |
| retx | input | 1 | Rewind strobe, active high |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 9 | Masked output register |
| dout_oe | output | 1 | High when dout is enabled |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| aempty_n | output | 1 | Low when at or below the almost-empty offset |
| afull_n | output | 1 | Low when at or above depth minus the almost-full offset |

## Verification
Several input patterns are used. Distinct words are written and read back to show ordering. A fill to capacity and a full drain check every flag transition and show that an overflow write was dropped. A simultaneous read and write shows whether the count moves. Reads on an empty buffer show whether the output register holds its value. Offset loads with values far from the defaults move both threshold edges, which separates the loaded values from the defaults. A rewind combined with a same-cycle write shows both the restart point and that the write was suppressed.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  localparam int DW = 9;
  localparam int DEF_OFFSET = 7;
  typedef logic [DW-1:0] word_t;
  typedef struct packed {
    word_t ae;
    word_t af;
  } offs_t;
endpackage

// File: rtl/pflag_fifo_store.sv
module pflag_fifo_store #(
  parameter int AW = 5,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pflag_offset_bank.sv
module pflag_offset_bank
  import pflag_fifo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_wr,
  input  logic  ld_rd,
  input  word_t din,
  output offs_t offs,
  output word_t rdata
);
  offs_t offs_q, offs_nx;
  logic  wsel_q, wsel_nx;
  logic  rsel_q, rsel_nx;

  always_comb begin
    offs_nx = offs_q;
    wsel_nx = wsel_q;
    rsel_nx = rsel_q;
    if (ld_wr) begin
      if (wsel_q) offs_nx.af = din;
      else        offs_nx.ae = din;
      wsel_nx = ~wsel_q;
    end
    if (ld_rd) rsel_nx = ~rsel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '{ae: word_t'(DEF_OFFSET), af: word_t'(DEF_OFFSET)};
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      offs_q <= offs_nx;
      wsel_q <= wsel_nx;
      rsel_q <= rsel_nx;
    end
  end

  assign offs  = offs_q;
  assign rdata = rsel_q ? offs_q.af : offs_q.ae;
endmodule

// File: rtl/pflag_flag_unit.sv
module pflag_flag_unit
  import pflag_fifo_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW:0] cnt_nx,
  input  offs_t       offs,
  output logic        empty_n,
  output logic        full_n,
  output logic        aempty_n,
  output logic        afull_n
);
  localparam int DEPTH = 1 << AW;
  localparam int XW = ((AW + 1) > DW ? (AW + 1) : DW) + 1;

  logic [XW-1:0] c_x, ae_x, af_x, depth_x;
  logic e_nx, f_nx, ae_nx, af_nx;

  always_comb begin
    c_x     = XW'(cnt_nx);
    ae_x    = XW'(offs.ae);
    af_x    = XW'(offs.af);
    depth_x = XW'(DEPTH);
    e_nx    = (c_x != '0);
    f_nx    = (c_x != depth_x);
    ae_nx   = !(c_x <= ae_x);
    af_nx   = !((c_x + af_x) >= depth_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_n  <= 1'b0;
      full_n   <= 1'b1;
      aempty_n <= 1'b0;
      afull_n  <= 1'b1;
    end else begin
      empty_n  <= e_nx;
      full_n   <= f_nx;
      aempty_n <= ae_nx;
      afull_n  <= af_nx;
    end
  end
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  input  logic          rd_n,
  input  logic          ld_n,
  input  logic          retx,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          empty_n,
  output logic          full_n,
  output logic          aempty_n,
  output logic          afull_n
);
  logic [AW-1:0] wp_q, wp_nx, rp_q, rp_nx;
  logic [AW:0]   cnt_q, cnt_nx;
  word_t         q_q, q_nx;
  word_t         mem_rd, off_rd;
  offs_t         offs;
  logic          wr_go, rd_go, ld_wr, ld_rd;

  assign wr_go = !wr_n && full_n && ld_n && !retx;
  assign rd_go = !rd_n && empty_n && ld_n && !retx;
  assign ld_wr = !ld_n && !wr_n;
  assign ld_rd = !ld_n && !rd_n;

  pflag_fifo_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(wr_go), .waddr(wp_q), .wdata(din),
    .raddr(rp_q), .rdata(mem_rd)
  );

  pflag_offset_bank u_offs (
    .clk(clk), .rst_n(rst_n), .ld_wr(ld_wr), .ld_rd(ld_rd),
    .din(din), .offs(offs), .rdata(off_rd)
  );

  pflag_flag_unit #(.AW(AW)) u_flags (
    .clk(clk), .rst_n(rst_n), .cnt_nx(cnt_nx), .offs(offs),
    .empty_n(empty_n), .full_n(full_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  always_comb begin
    wp_nx  = wr_go ? wp_q + 1'b1 : wp_q;
    rp_nx  = rp_q;
    cnt_nx = cnt_q;
    if (retx) begin
      rp_nx  = '0;
      cnt_nx = {1'b0, wp_q};
    end else begin
      if (rd_go) rp_nx = rp_q + 1'b1;
      case ({wr_go, rd_go})
        2'b10:   cnt_nx = cnt_q + 1'b1;
        2'b01:   cnt_nx = cnt_q - 1'b1;
        default: cnt_nx = cnt_q;
      endcase
    end
    q_nx = q_q;
    if (rd_go)      q_nx = mem_rd;
    else if (ld_rd) q_nx = off_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      q_q   <= '0;
    end else begin
      wp_q  <= wp_nx;
      rp_q  <= rp_nx;
      cnt_q <= cnt_nx;
      q_q   <= q_nx;
    end
  end

  assign dout    = oe_n ? '0 : q_q;
  assign dout_oe = ~oe_n;
endmodule

// File: rtl/pflag_fifo_checker.sv
module pflag_fifo_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_n,
  input logic       rd_n,
  input logic       ld_n,
  input logic       retx,
  input logic       oe_n,
  input logic [8:0] dout,
  input logic       dout_oe,
  input logic       empty_n,
  input logic       full_n,
  input logic       aempty_n,
  input logic       afull_n
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_n && rd_n && ld_n && !retx) |=> !full_n);

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wr_n && ld_n && !retx && !oe_n) |=> (!empty_n && (oe_n || $stable(dout))));

  assert_count_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && full_n && !wr_n && !rd_n && ld_n && !retx) |=> ($stable(empty_n) && $stable(full_n)));

  assert_empty_in_aempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  assert_full_in_afull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (!afull_n && empty_n));

  assert_oe_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dout == 9'd0 && !dout_oe));
endmodule

bind pflag_fifo pflag_fifo_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .ld_n(ld_n),
  .retx(retx), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe),
  .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
);

// File: tb/pflag_fifo_test.sv
`timescale 1ns/100ps
module pflag_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n, wr_n, rd_n, ld_n, retx, oe_n;
  logic [8:0] din;
  logic [8:0] dout;
  logic       dout_oe, empty_n, full_n, aempty_n, afull_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pflag_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .rd_n(rd_n),
    .ld_n(ld_n), .retx(retx), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [8:0] w);
    wr_n = 1'b0; din = w; cyc(); wr_n = 1'b1;
  endtask

  task automatic pop();
    rd_n = 1'b0; cyc(); rd_n = 1'b1;
  endtask

  task automatic do_reset();
    wr_n = 1'b1; rd_n = 1'b1; ld_n = 1'b1; retx = 1'b0; oe_n = 1'b0; din = '0;
    rst_n = 1'b0;
    cyc(); cyc();
    chk("R1 dout", dout, 0);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 afull_n", afull_n, 1);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_order();
    logic [8:0] v [4] = '{9'h101, 9'h0A5, 9'h15A, 9'h003};
    do_reset();
    foreach (v[i]) push(v[i]);
    chk("R2 not empty", empty_n, 1);
    foreach (v[i]) begin
      pop();
      chk("R2 order", dout, v[i]);
    end
    chk("R2 drained", empty_n, 0);
  endtask

  task automatic t_empty_read();
    pop(); pop();
    chk("R4 hold dout", dout, 9'h003);
    chk("R4 still empty", empty_n, 0);
  endtask

  task automatic t_simul();
    push(9'h011); push(9'h022);
    rd_n = 1'b0; wr_n = 1'b0; din = 9'h033; cyc(); rd_n = 1'b1; wr_n = 1'b1;
    chk("R5 read word", dout, 9'h011);
    pop(); chk("R5 second", dout, 9'h022);
    pop(); chk("R5 third", dout, 9'h033);
    chk("R5 count two", empty_n, 0);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 1; i <= 32; i++) begin
      push(9'(i));
      chk("R6 aempty", aempty_n, (i > 7) ? 1 : 0);
      chk("R7 afull", afull_n, (i < 25) ? 1 : 0);
      chk("R12 full", full_n, (i < 32) ? 1 : 0);
    end
    push(9'h1FF);
    chk("R3 stays full", full_n, 0);
    for (int i = 1; i <= 32; i++) begin
      pop();
      chk("R3 contents", dout, i);
    end
    chk("R3 empty after drain", empty_n, 0);
  endtask

  task automatic t_load();
    do_reset();
    ld_n = 1'b0;
    push(9'd3);
    push(9'd10);
    chk("R8 no fifo write", empty_n, 0);
    pop(); chk("R9 read ae", dout, 3);
    pop(); chk("R9 read af", dout, 10);
    ld_n = 1'b1;
    cyc();
    chk("R9 fifo untouched", empty_n, 0);
    for (int i = 1; i <= 22; i++) begin
      push(9'(i));
      if (i == 3)  chk("R8 ae at 3", aempty_n, 0);
      if (i == 4)  chk("R8 ae at 4", aempty_n, 1);
      if (i == 21) chk("R8 af at 21", afull_n, 1);
      if (i == 22) chk("R8 af at 22", afull_n, 0);
    end
  endtask

  task automatic t_retx();
    do_reset();
    push(9'h0AA); push(9'h0BB); push(9'h0CC); push(9'h0DD);
    pop(); pop();
    chk("R10 before rewind", dout, 9'h0BB);
    retx = 1'b1; wr_n = 1'b0; din = 9'h1EE; cyc(); retx = 1'b0; wr_n = 1'b1;
    pop(); chk("R10 first again", dout, 9'h0AA);
    pop(); chk("R10 second", dout, 9'h0BB);
    pop(); chk("R10 third", dout, 9'h0CC);
    pop(); chk("R10 fourth", dout, 9'h0DD);
    chk("R10 write dropped", empty_n, 0);
  endtask

  task automatic t_oe();
    oe_n = 1'b1; #1;
    chk("R11 masked dout", dout, 0);
    chk("R11 oe low", dout_oe, 0);
    oe_n = 1'b0; #1;
    chk("R11 dout back", dout, 9'h0DD);
    chk("R11 oe high", dout_oe, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_order();
    t_empty_read();
    t_simul();
    t_fill();
    t_load();
    t_retx();
    t_oe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule